// File: doc/BRIEF.md
# Two-Phase Stepper Microstep Translator

This block turns a stream of step pulses into current setpoints for the two windings of a bipolar stepper motor. It keeps a position on a 64-point electrical cycle, with the points 5.625 degrees apart. At each step it emits three things for each winding: a magnitude code, a polarity bit and a decay-mode flag. The magnitude codes follow |cos| for winding 1 and |sin| for winding 2, in units of 0.01 % of full-scale trip current. The decay flag tells the downstream chopper whether that winding's current fell, which needs mixed decay, or rose or held, which needs slow decay.

The step input is asynchronous. It passes through a two-flop synchroniser, and only its rising edge moves the position. The direction and resolution inputs are read at the moment the synchronised edge is seen, so they must be stable around the step pulse. Changes to them at any other time have no effect. The step size can change from one step to the next: each step adds or subtracts its own increment from the current position, modulo 64.

Top module: `stepper_xlate`

## Requirements
- R1: The resolution bits {res_a, res_b} select the increment per step: 00 gives 16 positions (full), 10 gives 8 (half), 01 gives 4 (quarter) and 11 gives 1 (sixteenth). The position wraps modulo 64, and the increment of each step is applied to whatever position is current.
- R2: With dir high the position moves to the next higher angle. With dir low it moves to the next lower angle.
- R3: At position p, ph1_mag equals round(10000·|cos(p·5.625°)|) and ph2_mag equals round(10000·|sin(p·5.625°)|).
- R4: phN_neg is 1 when that winding's signed value is negative and 0 when it is positive. When the magnitude is 0, phN_neg keeps its previous value.
- R5: After reset the position is 8 (45°). Both magnitudes are then 7071, both polarity bits are 0 and both decay flags are 1 (mixed).
- R6: On each step, phN_mixed becomes 1 if the new magnitude is lower than the previous one. It becomes 0 if the new magnitude is higher or equal.
- R7: Only a rising edge of step changes the outputs. A falling edge, a steady level, or a change on dir or the resolution bits without a step edge leaves every output unchanged.
- R8: While rst_n is low the outputs are held at the home values of R5 and step pulses are ignored. A step held high while reset is released causes no advance.
- R9: The outputs take their new values on the third rising clock edge after step rises. They are unchanged after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Asynchronous step pulse; the rising edge advances the position |
| dir | input | 1 | Direction: 1 for increasing angle, 0 for decreasing |
| res_a | input | 1 | Resolution select, first bit |
| res_b | input | 1 | Resolution select, second bit |
| ph1_mag | output | 14 | Winding 1 magnitude, in units of 0.01 % |
| ph1_neg | output | 1 | Winding 1 polarity (1 = negative) |
| ph1_mixed | output | 1 | Winding 1 decay: 1 mixed, 0 slow |
| ph2_mag | output | 14 | Winding 2 magnitude, in units of 0.01 % |
| ph2_neg | output | 1 | Winding 2 polarity (1 = negative) |
| ph2_mixed | output | 1 | Winding 2 decay: 1 mixed, 0 slow |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, home at position 8 and 14-bit magnitude codes. With these settings the 64-position cycle is short enough to sweep completely. Every resolution is run in both directions for more than one full revolution, so every table point, every zero crossing where the polarity must hold, and every wrap past position 0 are reached. The expected values are computed from trigonometric functions in the bench, and the bench adds targeted cases for mixed step sizes, reset with step held high, and the latency edge.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int POS_W      = 6;
  localparam int MAG_W      = 14;
  localparam int QTR        = 16;
  localparam int HALF_CYC   = 2 * QTR;
  localparam int FULL_SCALE = 10000;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [MAG_W-1:0] mag_t;

  // {first bit, second bit}
  typedef enum logic [1:0] {
    RES_FULL      = 2'b00,
    RES_QUARTER   = 2'b01,
    RES_HALF      = 2'b10,
    RES_SIXTEENTH = 2'b11
  } res_e;

  // quarter-wave of |sin| in 0.01 % units, index 0..16
  function automatic mag_t qsin(input logic [4:0] k);
    mag_t v;
    case (k)
      5'd0:  v = 14'd0;
      5'd1:  v = 14'd980;
      5'd2:  v = 14'd1951;
      5'd3:  v = 14'd2903;
      5'd4:  v = 14'd3827;
      5'd5:  v = 14'd4714;
      5'd6:  v = 14'd5556;
      5'd7:  v = 14'd6344;
      5'd8:  v = 14'd7071;
      5'd9:  v = 14'd7730;
      5'd10: v = 14'd8315;
      5'd11: v = 14'd8819;
      5'd12: v = 14'd9239;
      5'd13: v = 14'd9569;
      5'd14: v = 14'd9808;
      5'd15: v = 14'd9952;
      5'd16: v = 14'd10000;
      default: v = 14'd0;
    endcase
    return v;
  endfunction

  // magnitude of a winding at a position (m = position mod 32)
  function automatic mag_t mag_of(input logic [4:0] m, input bit is_sin);
    logic [5:0] k;
    if (is_sin) k = (m <= 5'd16) ? {1'b0, m} : (6'd32 - {1'b0, m});
    else        k = (m <= 5'd16) ? (6'd16 - {1'b0, m}) : ({1'b0, m} - 6'd16);
    return qsin(k[4:0]);
  endfunction

  // sign of a winding: 1 when strictly negative
  function automatic logic sign_of(input pos_t p, input bit is_sin);
    if (is_sin) return (p > pos_t'(HALF_CYC));
    return (p > pos_t'(QTR)) && (p < pos_t'(3 * QTR));
  endfunction

  function automatic pos_t step_incr(input res_e r);
    case (r)
      RES_FULL:    return pos_t'(QTR);
      RES_HALF:    return pos_t'(QTR / 2);
      RES_QUARTER: return pos_t'(QTR / 4);
      default:     return pos_t'(1);
    endcase
  endfunction
endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [STAGES:0] chain;

  // chain resets high so a level held through reset is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], d};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // R7
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/stx_index.sv
module stx_index
  import stx_pkg::*;
#(
  parameter int HOME_POS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic dir,
  input  res_e res,
  output pos_t pos,
  output pos_t pos_next
);
  pos_t incr;

  assign incr     = step_incr(res);
  assign pos_next = !adv ? pos : (dir ? pos + incr : pos - incr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= pos_t'(HOME_POS);
    else        pos <= pos_next;
  end

  // R7
  idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pos));
  // R1
  full_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && res == RES_FULL) |=> (pos[3:0] == $past(pos[3:0])));
  // R1
  half_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && res == RES_HALF) |=> (pos[2:0] == $past(pos[2:0])));
endmodule

// File: rtl/stx_phase.sv
module stx_phase
  import stx_pkg::*;
#(
  parameter bit IS_SIN   = 1'b0,
  parameter int HOME_POS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  pos_t pos_next,
  output mag_t mag,
  output logic neg,
  output logic mixed
);
  localparam pos_t HOME = pos_t'(HOME_POS);

  mag_t mag_new;
  logic zero_new;

  assign mag_new  = mag_of(pos_next[4:0], IS_SIN);
  assign zero_new = (mag_new == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag   <= mag_of(HOME[4:0], IS_SIN);
      neg   <= sign_of(HOME, IS_SIN);
      mixed <= 1'b1;
    end else if (adv) begin
      mag   <= mag_new;
      mixed <= (mag_new < mag);
      if (!zero_new) neg <= sign_of(pos_next, IS_SIN);
    end
  end

  // R6
  decay_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (mixed == (mag < $past(mag))));
  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable({mag, neg, mixed}));
  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(adv) && mag == '0) |-> (neg == $past(neg)));
  // R3
  always_comb begin
    mag_range_chk: assert (!rst_n || mag <= mag_t'(FULL_SCALE));
  end
endmodule

// File: rtl/stepper_xlate.sv
module stepper_xlate
  import stx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOME_POS    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             dir,
  input  logic             res_a,
  input  logic             res_b,
  output logic [MAG_W-1:0] ph1_mag,
  output logic             ph1_neg,
  output logic             ph1_mixed,
  output logic [MAG_W-1:0] ph2_mag,
  output logic             ph2_neg,
  output logic             ph2_mixed
);
  logic step_rise;
  res_e res_sel;
  pos_t pos, pos_next;

  assign res_sel = res_e'({res_a, res_b});

  stx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(step), .rise(step_rise)
  );

  stx_index #(.HOME_POS(HOME_POS)) u_index (
    .clk(clk), .rst_n(rst_n), .adv(step_rise), .dir(dir), .res(res_sel),
    .pos(pos), .pos_next(pos_next)
  );

  mag_t mags [2];
  logic negs [2];
  logic mixs [2];

  for (genvar g = 0; g < 2; g++) begin : g_ph
    stx_phase #(.IS_SIN(g == 1), .HOME_POS(HOME_POS)) u_ph (
      .clk(clk), .rst_n(rst_n), .adv(step_rise), .pos_next(pos_next),
      .mag(mags[g]), .neg(negs[g]), .mixed(mixs[g])
    );
  end

  assign ph1_mag   = mags[0];
  assign ph1_neg   = negs[0];
  assign ph1_mixed = mixs[0];
  assign ph2_mag   = mags[1];
  assign ph2_neg   = negs[1];
  assign ph2_mixed = mixs[1];

  // R5
  home_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ph1_mixed && ph2_mixed && !ph1_neg && !ph2_neg
                      && ph1_mag == ph2_mag));
  // R8
  no_reset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !step_rise);
  // R3
  pos_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos[3:0] == 4'd0) |-> (ph1_mag == '0 || ph2_mag == '0));
endmodule

// File: tb/tb_stepper_xlate.sv
`timescale 1ns/1ps
module tb_stepper_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, dir = 1'b1, res_a = 1'b0, res_b = 1'b0;
  logic [13:0] ph1_mag, ph2_mag;
  logic ph1_neg, ph1_mixed, ph2_neg, ph2_mixed;

  always #5 clk = ~clk;

  stepper_xlate dut (
    .clk(clk), .rst_n(rst_n), .step(step), .dir(dir), .res_a(res_a), .res_b(res_b),
    .ph1_mag(ph1_mag), .ph1_neg(ph1_neg), .ph1_mixed(ph1_mixed),
    .ph2_mag(ph2_mag), .ph2_neg(ph2_neg), .ph2_mixed(ph2_mixed)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  int m_pos;
  int m_mag [2];
  int m_neg [2];
  int m_mix [2];

  function automatic int emag(int p, bit s);
    real a, v;
    a = p * 5.625 * 3.14159265358979 / 180.0;
    v = s ? $sin(a) : $cos(a);
    if (v < 0.0) v = -v;
    return $rtoi(v * 10000.0 + 0.5);
  endfunction

  function automatic bit eneg(int p, bit s);
    real a;
    a = p * 5.625 * 3.14159265358979 / 180.0;
    return s ? ($sin(a) < 0.0) : ($cos(a) < 0.0);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_home();
    m_pos = 8;
    for (int i = 0; i < 2; i++) begin
      m_mag[i] = emag(8, i[0]); m_neg[i] = 0; m_mix[i] = 1;
    end
  endtask

  task automatic model_step(bit d, bit a, bit b);
    int inc;
    int nm;
    case ({a, b})
      2'b00: inc = 16;
      2'b10: inc = 8;
      2'b01: inc = 4;
      default: inc = 1;
    endcase
    m_pos = d ? (m_pos + inc) % 64 : (m_pos - inc + 64) % 64;
    for (int i = 0; i < 2; i++) begin
      nm = emag(m_pos, i[0]);
      m_mix[i] = (nm < m_mag[i]) ? 1 : 0;
      if (nm != 0) m_neg[i] = eneg(m_pos, i[0]) ? 1 : 0;
      m_mag[i] = nm;
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R3 ph1_mag"}, ph1_mag, m_mag[0]);
    chk({tag, " R3 ph2_mag"}, ph2_mag, m_mag[1]);
    chk({tag, " R4 ph1_neg"}, ph1_neg, m_neg[0]);
    chk({tag, " R4 ph2_neg"}, ph2_neg, m_neg[1]);
    chk({tag, " R6 ph1_mixed"}, ph1_mixed, m_mix[0]);
    chk({tag, " R6 ph2_mixed"}, ph2_mixed, m_mix[1]);
  endtask

  // one step; outputs sampled at negedges
  task automatic do_step(bit d, bit a, bit b, string tag);
    int old1;
    @(negedge clk);
    dir = d; res_a = a; res_b = b; step = 1'b1;
    old1 = ph1_mag;
    @(negedge clk); @(negedge clk);
    chk("R9 unchanged after second edge", ph1_mag, old1);
    @(negedge clk);
    model_step(d, a, b);
    check_all(tag);
    step = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 falling edge ph1_mag", ph1_mag, m_mag[0]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    model_home();
    repeat (3) @(negedge clk);
    check_all("R5 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R5 home");

    // R2 single sixteenth steps each way from home
    do_step(1'b1, 1'b1, 1'b1, "R2 up");
    chk("R2 up ph1_mag", ph1_mag, 6344);
    do_step(1'b0, 1'b1, 1'b1, "R2 back");
    do_step(1'b0, 1'b1, 1'b1, "R2 down");
    chk("R2 down ph1_mag", ph1_mag, 7730);
    do_step(1'b1, 1'b1, 1'b1, "R2 return");

    // R1 sweeps: every resolution, both directions, past a full cycle
    for (int r = 0; r < 4; r++) begin
      for (int d = 1; d >= 0; d--) begin
        int n;
        n = (r == 3) ? 70 : ((r == 0) ? 6 : (r == 1 ? 18 : 10));
        for (int k = 0; k < n; k++)
          do_step(d[0], r[1], r[0], "R1 sweep");
      end
    end

    // R1 mixed increments applied to the current index
    do_step(1'b1, 1'b1, 1'b1, "R1 mix a");
    do_step(1'b1, 1'b0, 1'b0, "R1 mix b");
    do_step(1'b0, 1'b0, 1'b1, "R1 mix c");
    do_step(1'b1, 1'b1, 1'b0, "R1 mix d");

    // R7 input changes without a step edge
    @(negedge clk);
    dir = ~dir; res_a = ~res_a; res_b = ~res_b;
    repeat (6) @(negedge clk);
    check_all("R7 no edge");

    // R8 reset mid-run, step pulses during reset, step high at release
    rst_n = 1'b0; model_home();
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      step = 1'b1; repeat (3) @(negedge clk);
      step = 1'b0; repeat (3) @(negedge clk);
    end
    check_all("R8 held in reset");
    step = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_all("R8 step high at release");
    step = 1'b0;
    repeat (3) @(negedge clk);
    do_step(1'b1, 1'b0, 1'b0, "R8 after release");

    finish_run();
  end
endmodule